// File: doc/BRIEF.md
# Power-Fail Store/Recall Sequencer

This controller sits beside a memory that keeps a nonvolatile shadow copy of its volatile array. Two digitized supply comparators feed it: one reports that the supply has dropped below a switch threshold, the other that it has fallen further, below a reset threshold. From these, from the write strobe of the memory port and from a software store request, the block decides when the volatile contents must be copied into the nonvolatile cells (a store) and when they must be copied back (a recall).

A store always runs in two ordered phases: an erase of the old nonvolatile data, then a program phase that writes the volatile data. While a store runs, the memory port is told to disable its inputs and outputs. An automatic store on power loss is only done when the array has been written since the last store or recall completed. A software store is always done. A dip below the reset threshold leaves a recall request pending, and that recall starts by itself once the supply is back above the switch threshold. Each phase lasts a number of clock cycles set by a parameter.

Top module: `pfail_nv_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `erase_o`, `program_o`, `recall_o`, `busy_o` and `io_disable_o` are all low.
- R2: When the block is idle and the array is dirty, a clock edge that samples `below_switch_i` high after it was sampled low in the previous cycle makes `erase_o` high in the next cycle.
- R3: A rise of `below_switch_i` starts no store when no write has been accepted since reset or since the last completed store or recall.
- R4: A `sw_store_req_i` sampled high while idle starts a store in the next cycle, whether the array is dirty or not.
- R5: A store holds `erase_o` high for exactly ERASE_CYC cycles, then at once `program_o` high for exactly PROG_CYC cycles, then returns to idle.
- R6: `io_disable_o` is high in exactly the erase and program cycles of a store and low during a recall; `busy_o` is high in every erase, program and recall cycle.
- R7: A cycle with `below_reset_i` sampled high leaves a recall request pending; it is held while `below_switch_i` stays high, the recall (`recall_o` high for exactly RESTORE_CYC cycles) starts the cycle after `below_switch_i` is sampled low while idle, and the request is cleared once taken.
- R8: A `wr_strobe_i` pulse accepted while idle marks the array dirty; completion of a store or of a recall clears that mark.
- R9: When a pending recall becomes ready in the same cycle as a store trigger, the recall runs and the store trigger is dropped.
- R10: A store request, a switch-threshold rise or a write strobe that arrives while busy has no effect, neither then nor after the running sequence ends.
- R11: At most one of `erase_o`, `program_o` and `recall_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| below_switch_i | input | 1 | Supply below switch threshold (digitized comparator) |
| below_reset_i | input | 1 | Supply below reset threshold (digitized comparator) |
| wr_strobe_i | input | 1 | One-cycle pulse per write on the memory port |
| sw_store_req_i | input | 1 | Software store request |
| erase_o | output | 1 | Erase phase of a store in progress |
| program_o | output | 1 | Program phase of a store in progress |
| recall_o | output | 1 | Recall in progress |
| busy_o | output | 1 | Any phase in progress |
| io_disable_o | output | 1 | Memory port inputs and outputs must be disabled |

## Verification
The store path is driven by three triggers: a switch-threshold rise with a clean array, the same rise after a write, and a software request with a clean array; together they separate the dirty gating of the automatic store from the unconditional software store. Dirty-clearing is probed by a second threshold rise after a store and after a recall, which tells whether each completion really resets the write mark. Brown-out patterns hold the switch comparator high for several cycles after the reset comparator drops, then release it alone or together with a software request, distinguishing a held recall request from an early or lost one and showing the recall winning the tie. Triggers and writes injected mid-store show whether a busy sequence can be restarted or can leave stale dirty state behind.

// File: rtl/pfail_pkg.sv
package pfail_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ERASE = 2'd1,
        PH_PROG  = 2'd2,
        PH_REST  = 2'd3
    } phase_e;

    typedef struct packed {
        logic bsw_prev;
        logic dirty;
        logic rcl_pend;
    } watch_t;

endpackage

// File: rtl/pfail_watch.sv
module pfail_watch
    import pfail_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic below_switch_i,
    input  logic below_reset_i,
    input  logic wr_strobe_i,
    input  logic busy_i,
    input  logic clr_dirty_i,
    input  logic take_recall_i,
    output logic auto_trig_o,
    output logic recall_ready_o,
    output logic dirty_o
);

    watch_t w_d, w_q;

    always_comb begin
        w_d          = w_q;
        w_d.bsw_prev = below_switch_i;
        if (clr_dirty_i) begin
            w_d.dirty = 1'b0;
        end else if (wr_strobe_i && !busy_i) begin
            w_d.dirty = 1'b1;
        end
        if (below_reset_i) begin
            w_d.rcl_pend = 1'b1;
        end else if (take_recall_i) begin
            w_d.rcl_pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign auto_trig_o    = below_switch_i && !w_q.bsw_prev && w_q.dirty;
    assign recall_ready_o = w_q.rcl_pend && !below_switch_i;
    assign dirty_o        = w_q.dirty;

    // R8
    dirty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_dirty_i |=> !w_q.dirty);

    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.rcl_pend && below_switch_i) |=> w_q.rcl_pend);

endmodule

// File: rtl/pfail_cnt.sv
module pfail_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pfail_nv_seq.sv
module pfail_nv_seq
    import pfail_pkg::*;
#(
    parameter int ERASE_CYC   = 4,
    parameter int PROG_CYC    = 6,
    parameter int RESTORE_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic below_switch_i,
    input  logic below_reset_i,
    input  logic wr_strobe_i,
    input  logic sw_store_req_i,
    output logic erase_o,
    output logic program_o,
    output logic recall_o,
    output logic busy_o,
    output logic io_disable_o
);

    localparam int MAX_A   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int MAX_LEN = (MAX_A > RESTORE_CYC) ? MAX_A : RESTORE_CYC;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    phase_e           phase_d, phase_q;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             cnt_zero;
    logic             done;
    logic             take_recall;
    logic             auto_trig;
    logic             recall_ready;
    logic             dirty;

    pfail_watch u_watch (
        .clk           (clk),
        .rst_n         (rst_n),
        .below_switch_i(below_switch_i),
        .below_reset_i (below_reset_i),
        .wr_strobe_i   (wr_strobe_i),
        .busy_i        (busy_o),
        .clr_dirty_i   (done),
        .take_recall_i (take_recall),
        .auto_trig_o   (auto_trig),
        .recall_ready_o(recall_ready),
        .dirty_o       (dirty)
    );

    pfail_cnt #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .load_val_i(load_val),
        .zero_o    (cnt_zero)
    );

    always_comb begin
        phase_d     = phase_q;
        load        = 1'b0;
        load_val    = '0;
        done        = 1'b0;
        take_recall = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (recall_ready) begin
                    phase_d     = PH_REST;
                    take_recall = 1'b1;
                    load        = 1'b1;
                    load_val    = CNT_W'(RESTORE_CYC - 1);
                end else if (auto_trig || sw_store_req_i) begin
                    phase_d  = PH_ERASE;
                    load     = 1'b1;
                    load_val = CNT_W'(ERASE_CYC - 1);
                end
            end
            PH_ERASE: begin
                if (cnt_zero) begin
                    phase_d  = PH_PROG;
                    load     = 1'b1;
                    load_val = CNT_W'(PROG_CYC - 1);
                end
            end
            PH_PROG: begin
                if (cnt_zero) begin
                    phase_d = PH_IDLE;
                    done    = 1'b1;
                end
            end
            PH_REST: begin
                if (cnt_zero) begin
                    phase_d = PH_IDLE;
                    done    = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign erase_o      = (phase_q == PH_ERASE);
    assign program_o    = (phase_q == PH_PROG);
    assign recall_o     = (phase_q == PH_REST);
    assign busy_o       = (phase_q != PH_IDLE);
    assign io_disable_o = erase_o || program_o;

    // R11
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_o, program_o, recall_o}));

    // R5
    erase_to_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_o) |-> program_o);

    // R5
    prog_after_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(program_o) |-> $past(erase_o));

    // R3
    clean_no_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_o) |-> ($past(sw_store_req_i) || $past(dirty)));

    // R7
    recall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recall_o) |-> $past(recall_ready));

    // R6
    io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_disable_o |-> (busy_o && !recall_o));

endmodule

// File: tb/test_pfail_nv_seq.sv
module test_pfail_nv_seq;

    localparam int E  = 4;
    localparam int P  = 6;
    localparam int RS = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bsw = 1'b0, brst = 1'b0, wr = 1'b0, sw = 1'b0;
    logic erase_o, program_o, recall_o, busy_o, io_disable_o;
    int   errors = 0;
    int   checks = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    pfail_nv_seq #(.ERASE_CYC(E), .PROG_CYC(P), .RESTORE_CYC(RS)) i_pfail_nv_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .below_switch_i(bsw),
        .below_reset_i (brst),
        .wr_strobe_i   (wr),
        .sw_store_req_i(sw),
        .erase_o       (erase_o),
        .program_o     (program_o),
        .recall_o      (recall_o),
        .busy_o        (busy_o),
        .io_disable_o  (io_disable_o)
    );

    // exp/act packed as {erase, program, recall, busy, io_disable}
    task automatic chk(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {erase_o, program_o, recall_o, busy_o, io_disable_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs act=%b exp=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_for(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            chk(req, 5'b00000);
            @(negedge clk);
        end
    endtask

    // Called at the negedge where the first erase cycle is visible.
    task automatic expect_store(input string req);
        for (int i = 0; i < E; i++) begin
            chk(req, 5'b10011);
            @(negedge clk);
        end
        for (int i = 0; i < P; i++) begin
            chk(req, 5'b01011);
            @(negedge clk);
        end
        chk(req, 5'b00000);
    endtask

    task automatic expect_recall(input string req);
        for (int i = 0; i < RS; i++) begin
            chk(req, 5'b00110);
            @(negedge clk);
        end
        chk(req, 5'b00000);
    endtask

    task automatic write_pulse();
        wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 in reset", 5'b00000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 5'b00000);
    endtask

    task automatic t_clean_auto();
        bsw = 1'b1;
        @(negedge clk);
        idle_for("R3 clean rise", 4);
        bsw = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_sw_store_clean();
        sw = 1'b1;
        @(negedge clk);
        sw = 1'b0;
        expect_store("R4 R5 R6 sw store clean");
    endtask

    task automatic t_auto_dirty();
        write_pulse();
        bsw = 1'b1;
        @(negedge clk);
        expect_store("R2 R5 auto store dirty");
        bsw = 1'b0;
        @(negedge clk);
        bsw = 1'b1;
        @(negedge clk);
        idle_for("R8 store cleared dirty", 4);
        bsw = 1'b0;
        @(negedge clk);
        write_pulse();
        sw = 1'b1;
        @(negedge clk);
        sw = 1'b0;
        expect_store("R4 sw store dirty");
        bsw = 1'b1;
        @(negedge clk);
        idle_for("R8 sw store cleared dirty", 3);
        bsw = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_recall();
        bsw = 1'b1;
        brst = 1'b1;
        @(negedge clk);
        idle_for("R7 no recall in brownout", 3);
        brst = 1'b0;
        idle_for("R7 held while below switch", 3);
        bsw = 1'b0;
        @(negedge clk);
        expect_recall("R7 R6 recall runs");
        @(negedge clk);
        idle_for("R7 request cleared", 4);
    endtask

    task automatic t_recall_clears_dirty();
        bsw = 1'b1;
        @(negedge clk);
        write_pulse();
        brst = 1'b1;
        @(negedge clk);
        brst = 1'b0;
        bsw = 1'b0;
        @(negedge clk);
        expect_recall("R7 recall after write");
        bsw = 1'b1;
        @(negedge clk);
        idle_for("R8 recall cleared dirty", 4);
        bsw = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_priority();
        bsw = 1'b1;
        brst = 1'b1;
        @(negedge clk);
        brst = 1'b0;
        @(negedge clk);
        bsw = 1'b0;
        sw = 1'b1;
        @(negedge clk);
        sw = 1'b0;
        expect_recall("R9 recall wins tie");
        @(negedge clk);
        idle_for("R9 store trigger dropped", 4);
    endtask

    task automatic t_busy_ignore();
        sw = 1'b1;
        @(negedge clk);
        sw = 1'b0;
        chk("R10 store first erase", 5'b10011);
        sw = 1'b1;
        wr = 1'b1;
        @(negedge clk);
        sw = 1'b0;
        wr = 1'b0;
        chk("R10 erase continues", 5'b10011);
        bsw = 1'b1;
        @(negedge clk);
        for (int i = 2; i < E; i++) begin
            chk("R10 erase length", 5'b10011);
            @(negedge clk);
        end
        for (int i = 0; i < P; i++) begin
            chk("R10 program length", 5'b01011);
            @(negedge clk);
        end
        idle_for("R10 no restart", 4);
        bsw = 1'b0;
        @(negedge clk);
        bsw = 1'b1;
        @(negedge clk);
        idle_for("R10 busy write ignored", 4);
        bsw = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_clean_auto();
        t_sw_store_clean();
        t_auto_dirty();
        t_recall();
        t_recall_clears_dirty();
        t_priority();
        t_busy_ignore();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule